// File: doc/BRIEF.md
# Biphase-Mark Audio Subframe Serializer

This block turns a stream of PCM audio samples into a single biphase-mark coded serial line, one 32-slot subframe at a time, with subframes alternating between channel 1 and channel 2. Each subframe opens with a fixed sync pattern. After that come the audio slots, a validity slot that is always zero, a user slot, a channel-status slot and an even-parity slot. The block runs from an oversampling clock with `OSR` clocks per slot, so with the default of eight a full two-channel frame takes 512 clocks.

Software or a DMA engine feeds samples through a two-stage buffer. The first stage is a single holding register whose empty flag is the refill request. The second stage is a pair of per-channel transmit registers. The write port reports which channel the next accepted write belongs to, starting with channel 1. A sample is consumed only by a subframe of its own channel. When no fresh sample is waiting for a channel, the last sample sent on that channel is sent again.

An external sequencer supplies the user bit, the channel-status bit and a block-start flag. It presents them during the cycle in which `sf_load` is high. That cycle is the last clock before the next subframe begins.

Top module: `bmc_subframe_tx`

## Requirements
- R1: `sf_load` is high for exactly one clock in every 32*OSR clocks, first in the clock right after reset is released. The subframe it announces begins on the following clock, and every slot lasts OSR clocks.
- R2: In slots 4 to 31 the line inverts at the start of every slot. It inverts again after OSR/2 clocks exactly when the slot's bit is 1.
- R3: Slots 0 to 3 carry eight half-slot levels. Relative to the line level before the subframe, written as first half to last half, with 1 meaning inverted, these are 11101000 for a channel-1 subframe loaded with `blk_start` high, 11100010 for a channel-1 subframe loaded with `blk_start` low, and 11100100 for every channel-2 subframe whatever `blk_start` is.
- R4: Slots 4 to 27 carry a 24-bit audio word, least significant bit first. The sample is placed left-justified, so its MSB is in slot 27 and the lowest 24-SAMPLE_W slots are 0.
- R5: Slot 28 (validity) is always 0.
- R6: Slot 29 carries `user_bit` and slot 30 carries `chstat_bit`, both as sampled in the `sf_load` clock.
- R7: Slot 31 makes the number of ones across slots 4 to 31 even.
- R8: `smp_empty` is high while the first stage holds no sample. A write is accepted only while `smp_empty` is high. A write while it is low changes nothing.
- R9: `smp_wr_chan` is 0 (channel 1) after reset and toggles on each accepted write. `sf_chan` gives the channel of the subframe being loaded (0 is channel 1) and alternates, starting with channel 1. A subframe takes the first-stage sample only if that sample was written for its channel.
- R10: A subframe with no matching fresh sample repeats the last sample sent on its channel, which is 0 after reset.
- R11: `line_out` is 0 in reset, and the line level carries over from one subframe to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OSR clocks per slot |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_wr_en | input | 1 | Sample write strobe |
| smp_wr_data | input | SAMPLE_W | PCM sample to write |
| smp_wr_chan | output | 1 | Channel of the next accepted write (0 is channel 1) |
| smp_empty | output | 1 | First buffer stage empty; refill request |
| user_bit | input | 1 | User slot value, sampled while sf_load is high |
| chstat_bit | input | 1 | Channel-status slot value, sampled while sf_load is high |
| blk_start | input | 1 | Marks the channel-1 subframe that opens a block, sampled while sf_load is high |
| sf_load | output | 1 | High in the last clock before a subframe starts |
| sf_chan | output | 1 | Channel of the subframe being loaded |
| line_out | output | 1 | Biphase-mark serial output |

## Verification
The hardest case to reach from the ports is a channel mismatch. In that case the first stage holds a sample tagged for channel 2 while a channel-1 subframe loads, so the buffer must leave it in place, repeat the old channel-1 sample, and refuse a further write. The stimulus gets there by writing a channel-2 sample during a channel-2 subframe, after the channel-1 sample has already been consumed. The next channel-1 subframe then meets a full but non-matching stage, and a write attempted during that subframe must be dropped. The line is decoded half-slot by half-slot against a model that carries the line level across subframes, so one missed or extra transition anywhere shows up in a later subframe too.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;

    localparam int SLOT_CNT     = 32;
    localparam int SLOT_W       = $clog2(SLOT_CNT);
    localparam int PRE_SLOT_CNT = 4;
    localparam int AUDIO_W      = 24;
    localparam int PAY_W        = SLOT_CNT - PRE_SLOT_CNT;
    localparam int VAL_SLOT     = PRE_SLOT_CNT + AUDIO_W;

    typedef enum logic [1:0] {
        SYNC_BLOCK = 2'd0,
        SYNC_CH1   = 2'd1,
        SYNC_CH2   = 2'd2
    } sync_kind_e;

    // Bit k is half-slot k of the sync pattern, relative to the prior line level.
    function automatic logic [7:0] sync_pattern(input sync_kind_e kind);
        case (kind)
            SYNC_BLOCK: return 8'b0001_0111;
            SYNC_CH1:   return 8'b0100_0111;
            default:    return 8'b0010_0111;
        endcase
    endfunction

endpackage

// File: rtl/bmc_slot_timer.sv
module bmc_slot_timer
    import bmc_tx_pkg::*;
#(
    parameter int OSR = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              load,
    output logic              load_chan,
    output logic              cell_edge,
    output logic              mid_edge,
    output logic [SLOT_W-1:0] slot_cur,
    output logic [SLOT_W-1:0] slot_nxt
);

    localparam int PH_W = $clog2(OSR);
    localparam int HALF = OSR / 2;

    typedef struct packed {
        logic [PH_W-1:0]   ph;
        logic [SLOT_W-1:0] slot;
        logic              chan;
    } timer_t;

    timer_t t_d, t_q;

    always_comb begin
        cell_edge = (t_q.ph == PH_W'(OSR - 1));
        mid_edge  = (t_q.ph == PH_W'(HALF - 1));
        load      = cell_edge && (t_q.slot == SLOT_W'(SLOT_CNT - 1));
        load_chan = ~t_q.chan;
        slot_cur  = t_q.slot;
        slot_nxt  = cell_edge ? t_q.slot + 1'b1 : t_q.slot;

        t_d = t_q;
        if (cell_edge) begin
            t_d.ph   = '0;
            t_d.slot = t_q.slot + 1'b1;
        end else begin
            t_d.ph = t_q.ph + 1'b1;
        end
        if (load) begin
            t_d.chan = ~t_q.chan;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.ph   <= PH_W'(OSR - 1);
            t_q.slot <= SLOT_W'(SLOT_CNT - 1);
            t_q.chan <= 1'b1;
        end else begin
            t_q <= t_d;
        end
    end

    assert_subframe_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (t_q.slot == '0) && (t_q.ph == '0));

    assert_chan_alternate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (t_q.chan != $past(t_q.chan)));

endmodule

// File: rtl/bmc_sample_buf.sv
module bmc_sample_buf
    import bmc_tx_pkg::*;
#(
    parameter int SAMPLE_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SAMPLE_W-1:0] wr_data,
    input  logic               load,
    input  logic               load_chan,
    output logic               wr_chan,
    output logic               empty,
    output logic [AUDIO_W-1:0] audio
);

    localparam int PAD = AUDIO_W - SAMPLE_W;

    typedef struct packed {
        logic                     s1_valid;
        logic                     s1_tag;
        logic [SAMPLE_W-1:0]      s1_data;
        logic [1:0][SAMPLE_W-1:0] hold;
        logic                     wchan;
    } buf_t;

    buf_t b_d, b_q;
    logic                take_s1;
    logic [SAMPLE_W-1:0] chosen;

    always_comb begin
        take_s1 = b_q.s1_valid && (b_q.s1_tag == load_chan);
        chosen  = take_s1 ? b_q.s1_data : b_q.hold[load_chan];
        audio   = AUDIO_W'(chosen) << PAD;
        empty   = ~b_q.s1_valid;
        wr_chan = b_q.wchan;

        b_d = b_q;
        if (load && take_s1) begin
            b_d.hold[load_chan] = b_q.s1_data;
            b_d.s1_valid        = 1'b0;
        end
        if (wr_en && !b_q.s1_valid) begin
            b_d.s1_valid = 1'b1;
            b_d.s1_tag   = b_q.wchan;
            b_d.s1_data  = wr_data;
            b_d.wchan    = ~b_q.wchan;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assert_full_write_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (b_q.s1_valid && !load && wr_en) |=>
            (b_q.s1_valid && $stable(b_q.s1_data) && $stable(b_q.s1_tag)));

    assert_wchan_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !b_q.s1_valid) |=> $stable(b_q.wchan));

    assert_underrun_keeps_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !(b_q.s1_valid && b_q.s1_tag == load_chan)) |=> $stable(b_q.hold));

endmodule

// File: rtl/bmc_line_coder.sv
module bmc_line_coder
    import bmc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              cell_edge,
    input  logic              mid_edge,
    input  logic [SLOT_W-1:0] slot_cur,
    input  logic [SLOT_W-1:0] slot_nxt,
    input  sync_kind_e        kind_in,
    input  logic [PAY_W-1:0]  payload,
    output logic              line
);

    typedef struct packed {
        logic             line;
        logic             ref_lvl;
        sync_kind_e       kind;
        logic [PAY_W-1:0] shift;
    } coder_t;

    coder_t c_d, c_q;
    logic       ref_use;
    logic [7:0] pat;
    logic [2:0] idx_first;
    logic [2:0] idx_second;

    always_comb begin
        ref_use    = load ? c_q.line : c_q.ref_lvl;
        pat        = sync_pattern(load ? kind_in : c_q.kind);
        idx_first  = {slot_nxt[1:0], 1'b0};
        idx_second = {slot_cur[1:0], 1'b1};

        c_d = c_q;
        if (load) begin
            c_d.ref_lvl = c_q.line;
            c_d.kind    = kind_in;
            c_d.shift   = payload;
        end
        if (cell_edge) begin
            if (slot_nxt < SLOT_W'(PRE_SLOT_CNT)) begin
                c_d.line = pat[idx_first] ^ ref_use;
            end else begin
                c_d.line = ~c_q.line;
                if (slot_nxt > SLOT_W'(PRE_SLOT_CNT)) begin
                    c_d.shift = c_q.shift >> 1;
                end
            end
        end else if (mid_edge) begin
            if (slot_cur < SLOT_W'(PRE_SLOT_CNT)) begin
                c_d.line = pat[idx_second] ^ c_q.ref_lvl;
            end else if (c_q.shift[0]) begin
                c_d.line = ~c_q.line;
            end
        end
        line = c_q.line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.line    <= 1'b0;
            c_q.ref_lvl <= 1'b0;
            c_q.kind    <= SYNC_BLOCK;
            c_q.shift   <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assert_cell_start_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_edge && slot_nxt >= SLOT_W'(PRE_SLOT_CNT)) |=> (c_q.line != $past(c_q.line)));

    assert_validity_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_edge && slot_cur == SLOT_W'(VAL_SLOT)) |=> $stable(c_q.line));

    assert_even_parity_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (c_q.line == c_q.ref_lvl));

endmodule

// File: rtl/bmc_subframe_tx.sv
module bmc_subframe_tx
    import bmc_tx_pkg::*;
#(
    parameter int OSR      = 8,
    parameter int SAMPLE_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_wr_en,
    input  logic [SAMPLE_W-1:0] smp_wr_data,
    output logic                smp_wr_chan,
    output logic                smp_empty,
    input  logic                user_bit,
    input  logic                chstat_bit,
    input  logic                blk_start,
    output logic                sf_load,
    output logic                sf_chan,
    output logic                line_out
);

    logic               load;
    logic               load_chan;
    logic               cell_edge;
    logic               mid_edge;
    logic [SLOT_W-1:0]  slot_cur;
    logic [SLOT_W-1:0]  slot_nxt;
    logic [AUDIO_W-1:0] audio;
    logic [PAY_W-1:0]   payload;
    logic               parity;
    sync_kind_e         kind;

    bmc_slot_timer #(.OSR(OSR)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_chan (load_chan),
        .cell_edge (cell_edge),
        .mid_edge  (mid_edge),
        .slot_cur  (slot_cur),
        .slot_nxt  (slot_nxt)
    );

    bmc_sample_buf #(.SAMPLE_W(SAMPLE_W)) buf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (smp_wr_en),
        .wr_data   (smp_wr_data),
        .load      (load),
        .load_chan (load_chan),
        .wr_chan   (smp_wr_chan),
        .empty     (smp_empty),
        .audio     (audio)
    );

    always_comb begin
        parity  = ^{chstat_bit, user_bit, audio};
        payload = {parity, chstat_bit, user_bit, 1'b0, audio};
        if (load_chan) begin
            kind = SYNC_CH2;
        end else if (blk_start) begin
            kind = SYNC_BLOCK;
        end else begin
            kind = SYNC_CH1;
        end
        sf_load = load;
        sf_chan = load_chan;
    end

    bmc_line_coder coder_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .cell_edge (cell_edge),
        .mid_edge  (mid_edge),
        .slot_cur  (slot_cur),
        .slot_nxt  (slot_nxt),
        .kind_in   (kind),
        .payload   (payload),
        .line      (line_out)
    );

endmodule

// File: tb/bmc_subframe_tx_tb_top.sv
module bmc_subframe_tx_tb_top;

    localparam int OSR = 8;
    localparam int H   = OSR / 2;
    localparam int SW  = 20;
    localparam int AW  = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_wr_en = 1'b0;
    logic [SW-1:0] smp_wr_data = '0;
    logic          smp_wr_chan;
    logic          smp_empty;
    logic          user_bit = 1'b0;
    logic          chstat_bit = 1'b0;
    logic          blk_start = 1'b0;
    logic          sf_load;
    logic          sf_chan;
    logic          line_out;

    int  n_total = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    logic lvl    = 1'b0;

    always #5 clk = ~clk;

    bmc_subframe_tx #(.OSR(OSR), .SAMPLE_W(SW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_wr_en   (smp_wr_en),
        .smp_wr_data (smp_wr_data),
        .smp_wr_chan (smp_wr_chan),
        .smp_empty   (smp_empty),
        .user_bit    (user_bit),
        .chstat_bit  (chstat_bit),
        .blk_start   (blk_start),
        .sf_load     (sf_load),
        .sf_chan     (sf_chan),
        .line_out    (line_out)
    );

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic reset_scenario();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(line_out == 1'b0, "R11 line low in reset", 64'(line_out), 64'd0);
        check(smp_empty == 1'b1, "R8 empty in reset", 64'(smp_empty), 64'd1);
        check(smp_wr_chan == 1'b0, "R9 write channel 1 after reset", 64'(smp_wr_chan), 64'd0);
        rst_n = 1'b1;
        check(sf_load == 1'b1, "R1 load right after reset", 64'(sf_load), 64'd1);
    endtask

    // One subframe: drives sequencer bits, optional write, decodes all 64 half-slots.
    task automatic run_sf(input string nm, input logic ch, input logic bs, input logic u,
                          input logic c, input logic [SW-1:0] smp, input logic do_wr,
                          input logic [SW-1:0] wv, input logic exp_empty0,
                          input logic exp_empty1, input logic exp_wchan1);
        logic [AW-1:0] aud;
        logic [31:0]   bits;
        logic [0:7]    pat;
        logic [63:0]   eh;
        logic [63:0]   gh;
        logic          ref_lvl;
        int            loads;
        blk_start  = bs;
        user_bit   = u;
        chstat_bit = c;
        while (!sf_load) @(negedge clk);
        check(sf_chan == ch, {"R9 subframe channel ", nm}, 64'(sf_chan), 64'(ch));

        aud        = AW'(smp) << (AW - SW);
        bits       = '0;
        bits[27:4] = aud;
        bits[28]   = 1'b0;
        bits[29]   = u;
        bits[30]   = c;
        bits[31]   = ^{c, u, aud};
        if (ch)      pat = 8'b11100100;
        else if (bs) pat = 8'b11101000;
        else         pat = 8'b11100010;
        ref_lvl = lvl;
        eh = '0;
        for (int k = 0; k < 8; k++) eh[k] = pat[k] ^ ref_lvl;
        lvl = pat[7] ^ ref_lvl;
        for (int s = 4; s < 32; s++) begin
            lvl = ~lvl;
            eh[2*s] = lvl;
            if (bits[s]) lvl = ~lvl;
            eh[2*s+1] = lvl;
        end

        loads = 0;
        gh = '0;
        for (int h = 0; h < 64; h++) begin
            @(negedge clk);
            gh[h] = line_out;
            if (sf_load) loads++;
            if (h == 0) begin
                check(smp_empty == exp_empty0, {"R8 empty at subframe start ", nm},
                      64'(smp_empty), 64'(exp_empty0));
                smp_wr_en   = do_wr;
                smp_wr_data = wv;
            end
            if (h == 1) begin
                check(smp_empty == exp_empty1, {"R8 empty after write ", nm},
                      64'(smp_empty), 64'(exp_empty1));
                check(smp_wr_chan == exp_wchan1, {"R9 write channel after write ", nm},
                      64'(smp_wr_chan), 64'(exp_wchan1));
            end
            for (int r = 1; r < H; r++) begin
                @(negedge clk);
                smp_wr_en = 1'b0;
                if (sf_load) loads++;
            end
        end
        check(loads == 1 && sf_load == 1'b1, {"R1 one load per subframe ", nm},
              64'(loads), 64'd1);
        check(gh[0] == eh[0], {"R11 level carried into ", nm}, 64'(gh[0]), 64'(eh[0]));
        check(gh[7:0] == eh[7:0], {"R3 sync pattern ", nm}, 64'(gh[7:0]), 64'(eh[7:0]));
        check(gh[55:8] == eh[55:8], {"R2 R4 audio slots ", nm}, 64'(gh[55:8]), 64'(eh[55:8]));
        check(gh[57:56] == eh[57:56], {"R5 validity slot ", nm}, 64'(gh[57:56]), 64'(eh[57:56]));
        check(gh[61:58] == eh[61:58], {"R6 user and status slots ", nm}, 64'(gh[61:58]), 64'(eh[61:58]));
        check(gh[63:62] == eh[63:62], {"R7 parity slot ", nm}, 64'(gh[63:62]), 64'(eh[63:62]));
    endtask

    initial begin
        reset_scenario();
        // channel 1 block start, underrun sends zero; write A for channel 1
        run_sf("sf0", 1'b0, 1'b1, 1'b0, 1'b0, 20'h00000, 1'b1, 20'hA5C3E, 1'b1, 1'b0, 1'b1);
        // channel 2: A stays (tag mismatch), write while full is dropped (R8)
        run_sf("sf1", 1'b1, 1'b0, 1'b1, 1'b0, 20'h00000, 1'b1, 20'h12345, 1'b0, 1'b0, 1'b1);
        // channel 1 sends A, then write B for channel 2
        run_sf("sf2", 1'b0, 1'b0, 1'b0, 1'b1, 20'hA5C3E, 1'b1, 20'h0F0F1, 1'b1, 1'b0, 1'b0);
        // channel 2 sends B, write C for channel 1
        run_sf("sf3", 1'b1, 1'b0, 1'b1, 1'b1, 20'h0F0F1, 1'b1, 20'hFFFFF, 1'b1, 1'b0, 1'b1);
        // channel 1 sends all-ones C
        run_sf("sf4", 1'b0, 1'b0, 1'b0, 1'b1, 20'hFFFFF, 1'b0, 20'h00000, 1'b1, 1'b1, 1'b1);
        // channel 2 underrun repeats B (R10); write D for channel 2
        run_sf("sf5", 1'b1, 1'b0, 1'b0, 1'b0, 20'h0F0F1, 1'b1, 20'h00001, 1'b1, 1'b0, 1'b0);
        // channel 1 with channel-2 sample waiting: repeat C (R10), drop write (R8)
        run_sf("sf6", 1'b0, 1'b1, 1'b1, 1'b0, 20'hFFFFF, 1'b1, 20'h55555, 1'b0, 1'b0, 1'b0);
        // channel 2 with block start high still gets its own sync (R3); write F
        run_sf("sf7", 1'b1, 1'b1, 1'b0, 1'b1, 20'h00001, 1'b1, 20'h80000, 1'b1, 1'b0, 1'b1);
        run_sf("sf8", 1'b0, 1'b0, 1'b1, 1'b0, 20'h80000, 1'b0, 20'h00000, 1'b1, 1'b1, 1'b1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog R1 actual=%h expected=%h", 64'd0, 64'd1);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule